// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

The block gathers interrupt requests from a set of peripheral request lines and from a small bank of flags that software sets. Every source has its own 4-bit priority level, set by software. The controller shows the processor the winning pending request as a 9-bit vector number that belongs to that source alone. Among pending sources, the highest programmed level wins. When levels are equal, the lowest vector number wins.

A running-level register masks every request whose level is not strictly above it. When the processor acknowledges a request, the old running level is saved on a 16-entry level stack and the running level is raised to the level of the accepted source. A write to the end-of-service register restores the saved level. Software can also write the running level directly. Raising it for the length of a critical section keeps tasks that share a resource from preempting one another, which is a priority ceiling.

Registers are reached through a single-cycle write port with a combinational read path. Both the arbitration result and the vector are registered.

Top module: `vpic_top`

## Requirements
- R1: After reset the following hold: `irq_req` is low, the running level is 0, every source level is 0, and every software flag is clear.
- R2: Software flag k (k = 0..7) uses vector k. Hardware line i (i = 0..31) uses vector 8+i. The vector is 9 bits wide and is always below 40 while `irq_req` is high.
- R3: Writing address 0x02 changes the software flags. Data bits [7:0] set flags and bits [15:8] clear flags. If a flag gets a set and a clear in the same write, it ends up set. A read of 0x02 returns the flags in bits [7:0].
- R4: The level of the source with vector v sits at address 0x40+v in bits [3:0]. It can be written and read back.
- R5: Of the pending sources, the one with the highest level is presented.
- R6: If several pending sources share the highest level, the lowest vector number is presented.
- R7: A source whose level is 0 never raises a request.
- R8: `irq_req` is asserted only when the winner's level is strictly greater than the running level. The running level is at address 0x00, bits [3:0], and can be read and written.
- R9: `irq_req` and `irq_vec` are registered. A change in the inputs, the flags, the levels or the running level shows at the outputs one clock later.
- R10: `irq_ack` sampled while `irq_req` is high has three effects. It pushes the running level onto the stack. It loads the running level with the level of the presented source. It forces `irq_req` low in the next cycle. An `irq_ack` sampled while `irq_req` is low has no effect.
- R11: Any write to address 0x01 pops the stack into the running level. If the stack is empty, the running level becomes 0.
- R12: If an acknowledge is taken in the same cycle as a write to 0x00 or 0x01, the acknowledge takes effect and that write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hw_irq | input | 32 | Level-sensitive peripheral request lines |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational on `reg_addr` |
| irq_req | output | 1 | Request to the processor |
| irq_vec | output | 9 | Vector of the presented source |
| irq_ack | input | 1 | Processor accepts the presented request |

## Verification
The bench targets the following corner cases:
- **Equal-level tie-break.** Two lines share a level, and a software flag ties with a line. A design that scans in the wrong direction presents the higher vector.
- **Masking boundary.** A source whose level equals the running level must stay masked. A `>=` compare would let it preempt its own ceiling.
- **Acknowledge and end-of-service.** A design that does not clear the request on acknowledge issues a spurious second request for one cycle. A stack that restores the wrong entry leaves the running level wrong after nested service.
- **Register races.** An acknowledge can coincide with a write to the running level or to end-of-service, and a flag can get a set and a clear in the same write. A design with the wrong precedence changes the running level or the flag in a way the requirements forbid.

A random phase then mixes all of these against the bench model, cycle by cycle.

// File: rtl/vpic_pkg.sv
package vpic_pkg;

    localparam int PRIO_W     = 4;
    localparam int VEC_W      = 9;
    localparam int ADDR_W     = 8;
    localparam int DATA_W     = 32;
    localparam int PRIO_BASE  = 64;

    localparam logic [ADDR_W-1:0] A_LEVEL = 8'h00;
    localparam logic [ADDR_W-1:0] A_EOI   = 8'h01;
    localparam logic [ADDR_W-1:0] A_SWI   = 8'h02;

    typedef logic [PRIO_W-1:0] prio_t;
    typedef logic [VEC_W-1:0]  vec_t;

    typedef struct packed {
        logic  hit;
        prio_t prio;
        vec_t  vec;
    } win_t;

endpackage

// File: rtl/vpic_arb.sv
module vpic_arb
    import vpic_pkg::*;
#(
    parameter int NUM_SRC = 40
) (
    input  logic [NUM_SRC-1:0]        pend,
    input  logic [NUM_SRC*PRIO_W-1:0] prio_flat,
    output win_t                      win
);

    // Ascending scan with a strict compare: the first source to reach the
    // maximum (lowest vector) is kept, and level 0 can never be selected.
    always_comb begin
        win = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (pend[i] && (prio_flat[i*PRIO_W +: PRIO_W] > win.prio)) begin
                win.hit  = 1'b1;
                win.prio = prio_flat[i*PRIO_W +: PRIO_W];
                win.vec  = VEC_W'(i);
            end
        end
    end

endmodule

// File: rtl/vpic_lifo.sv
module vpic_lifo
    import vpic_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic             pop,
    input  prio_t            din,
    output prio_t            top,
    output logic [CNT_W-1:0] cnt
);

    prio_t mem [DEPTH];
    logic  full, empty;

    assign full  = (cnt == CNT_W'(DEPTH));
    assign empty = (cnt == '0);
    assign top   = empty ? '0 : mem[IDX_W'(cnt - 1'b1)];

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (push) begin
            if (!full) cnt <= cnt + 1'b1;
        end else if (pop && !empty) begin
            cnt <= cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (push && !full) mem[IDX_W'(cnt)] <= din;
    end

endmodule

// File: rtl/vpic_regs.sv
module vpic_regs
    import vpic_pkg::*;
#(
    parameter int NUM_SRC = 40,
    parameter int NUM_SW  = 8
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      wr,
    input  logic [ADDR_W-1:0]         addr,
    input  logic [DATA_W-1:0]         wdata,
    input  logic                      ack_take,
    input  prio_t                     ack_prio,
    input  prio_t                     pop_val,
    output prio_t                     level,
    output logic [NUM_SW-1:0]         sw_flags,
    output logic [NUM_SRC*PRIO_W-1:0] prio_flat,
    output logic                      eoi_pop,
    output logic [DATA_W-1:0]         rdata
);

    logic  hit_level, hit_swi;
    prio_t prio_r [NUM_SRC];

    assign hit_level = wr && (addr == A_LEVEL);
    assign hit_swi   = wr && (addr == A_SWI);
    assign eoi_pop   = wr && (addr == A_EOI) && !ack_take;

    // Acknowledge outranks both software paths to the running level.
    always_ff @(posedge clk) begin
        if (rst)                            level <= '0;
        else if (ack_take)                  level <= ack_prio;
        else if (hit_level)                 level <= wdata[PRIO_W-1:0];
        else if (eoi_pop)                   level <= pop_val;
    end

    // Set applied after clear so a simultaneous pair leaves the flag set.
    always_ff @(posedge clk) begin
        if (rst)          sw_flags <= '0;
        else if (hit_swi) sw_flags <= (sw_flags & ~wdata[2*NUM_SW-1:NUM_SW])
                                      | wdata[NUM_SW-1:0];
    end

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_prio
        always_ff @(posedge clk) begin
            if (rst) prio_r[g] <= '0;
            else if (wr && (addr == ADDR_W'(PRIO_BASE + g)))
                prio_r[g] <= wdata[PRIO_W-1:0];
        end
        assign prio_flat[g*PRIO_W +: PRIO_W] = prio_r[g];
    end

    always_comb begin
        rdata = '0;
        if (addr == A_LEVEL) rdata = DATA_W'(level);
        if (addr == A_SWI)   rdata = DATA_W'(sw_flags);
        for (int i = 0; i < NUM_SRC; i++) begin
            if (addr == ADDR_W'(PRIO_BASE + i)) rdata = DATA_W'(prio_r[i]);
        end
    end

endmodule

// File: rtl/vpic_top.sv
module vpic_top
    import vpic_pkg::*;
#(
    parameter int NUM_HW     = 32,
    parameter int NUM_SW     = 8,
    parameter int LIFO_DEPTH = 16,
    localparam int NUM_SRC   = NUM_HW + NUM_SW,
    localparam int CNT_W     = $clog2(LIFO_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_HW-1:0] hw_irq,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq_req,
    output logic [VEC_W-1:0]  irq_vec,
    input  logic              irq_ack
);

    prio_t                     level, lifo_top, win_prio_q;
    logic [NUM_SW-1:0]         sw_flags;
    logic [NUM_SRC*PRIO_W-1:0] prio_flat;
    logic                      eoi_pop, ack_take, req_q;
    logic [CNT_W-1:0]          lifo_cnt;
    win_t                      win, win_q;

    assign ack_take   = irq_ack && req_q;
    assign win_prio_q = win_q.prio;

    vpic_regs #(.NUM_SRC(NUM_SRC), .NUM_SW(NUM_SW)) i_regs (
        .clk      (clk),
        .rst      (rst),
        .wr       (reg_wr),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .ack_take (ack_take),
        .ack_prio (win_q.prio),
        .pop_val  (lifo_top),
        .level    (level),
        .sw_flags (sw_flags),
        .prio_flat(prio_flat),
        .eoi_pop  (eoi_pop),
        .rdata    (reg_rdata)
    );

    vpic_arb #(.NUM_SRC(NUM_SRC)) i_arb (
        .pend     ({hw_irq, sw_flags}),
        .prio_flat(prio_flat),
        .win      (win)
    );

    vpic_lifo #(.DEPTH(LIFO_DEPTH)) i_lifo (
        .clk (clk),
        .rst (rst),
        .push(ack_take),
        .pop (eoi_pop),
        .din (level),
        .top (lifo_top),
        .cnt (lifo_cnt)
    );

    // Acknowledge blanks the request for one cycle so the next compare
    // sees the raised running level.
    always_ff @(posedge clk) begin
        if (rst) begin
            req_q <= 1'b0;
            win_q <= '0;
        end else begin
            win_q <= win;
            req_q <= !ack_take && win.hit && (win.prio > level);
        end
    end

    assign irq_req = req_q;
    assign irq_vec = win_q.vec;

endmodule

// File: rtl/vpic_chk.sv
module vpic_chk
    import vpic_pkg::*;
#(
    parameter int NUM_SRC    = 40,
    parameter int NUM_SW     = 8,
    parameter int LIFO_DEPTH = 16,
    localparam int CNT_W     = $clog2(LIFO_DEPTH + 1)
) (
    input logic              clk,
    input logic              rst,
    input logic              irq_req,
    input logic              irq_ack,
    input logic [VEC_W-1:0]  irq_vec,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [DATA_W-1:0] reg_wdata,
    input prio_t             level,
    input prio_t             win_prio_q,
    input prio_t             lifo_top,
    input logic [CNT_W-1:0]  lifo_cnt,
    input logic [NUM_SW-1:0] sw_flags
);

    AST_VEC_RANGE: assert property (@(posedge clk) disable iff (rst)
        irq_req |-> irq_vec < VEC_W'(NUM_SRC)); // R2

    AST_REQ_ABOVE_LEVEL: assert property (@(posedge clk) disable iff (rst)
        irq_req |-> win_prio_q > $past(level)); // R8

    AST_ACK_DROPS_REQ: assert property (@(posedge clk) disable iff (rst)
        (irq_req && irq_ack) |=> !irq_req); // R10

    AST_ACK_LOADS_LEVEL: assert property (@(posedge clk) disable iff (rst)
        (irq_req && irq_ack) |=> level == $past(win_prio_q)); // R10

    AST_ACK_PUSHES: assert property (@(posedge clk) disable iff (rst)
        (irq_req && irq_ack && lifo_cnt < CNT_W'(LIFO_DEPTH))
        |=> (lifo_cnt == $past(lifo_cnt) + 1'b1) && (lifo_top == $past(level))); // R10

    AST_EOI_RESTORES: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == A_EOI && !(irq_req && irq_ack))
        |=> level == $past(lifo_top)); // R11

    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == A_SWI)
        |=> (sw_flags & $past(reg_wdata[NUM_SW-1:0])) == $past(reg_wdata[NUM_SW-1:0])); // R3

    AST_ACK_OVER_WRITE: assert property (@(posedge clk) disable iff (rst)
        (irq_req && irq_ack && reg_wr && reg_addr == A_LEVEL)
        |=> level == $past(win_prio_q)); // R12

endmodule

bind vpic_top vpic_chk #(
    .NUM_SRC   (NUM_SRC),
    .NUM_SW    (NUM_SW),
    .LIFO_DEPTH(LIFO_DEPTH)
) i_chk (
    .clk       (clk),
    .rst       (rst),
    .irq_req   (irq_req),
    .irq_ack   (irq_ack),
    .irq_vec   (irq_vec),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .level     (level),
    .win_prio_q(win_prio_q),
    .lifo_top  (lifo_top),
    .lifo_cnt  (lifo_cnt),
    .sw_flags  (sw_flags)
);

// File: tb/test_vpic_top.sv
module test_vpic_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] hw = '0;
    logic        wr = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        req;
    logic [8:0]  vec;
    logic        ack = 1'b0;

    int nchk = 0;
    int nerr = 0;

    // behavioural reference state
    int m_prio [40];
    bit [7:0] m_sw = '0;
    int m_level = 0;
    int m_stack [$];
    bit m_req = 1'b0;
    int m_vec = 0;
    int m_wp = 0;

    always #4 clk = ~clk;

    vpic_top i_vpic_top (
        .clk(clk), .rst(rst), .hw_irq(hw), .reg_wr(wr), .reg_addr(addr),
        .reg_wdata(wdata), .reg_rdata(rdata), .irq_req(req), .irq_vec(vec),
        .irq_ack(ack)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Model one clock edge, advance the design, compare outputs.
    task automatic tick();
        int  bp = 0;
        int  bv = 0;
        bit  take;
        bit  pend;
        int  old_level;
        for (int i = 0; i < 40; i++) begin
            pend = (i < 8) ? m_sw[i] : hw[i-8];
            if (pend && m_prio[i] > bp) begin
                bp = m_prio[i];
                bv = i;
            end
        end
        take = ack && m_req;
        old_level = m_level;
        if (take) begin
            if (m_stack.size() < 16) m_stack.push_back(m_level);
            m_level = m_wp;
        end else if (wr && addr == 8'h00) begin
            m_level = int'(wdata[3:0]);
        end else if (wr && addr == 8'h01) begin
            m_level = (m_stack.size() > 0) ? m_stack.pop_back() : 0;
        end
        if (wr && addr == 8'h02) m_sw = (m_sw & ~wdata[15:8]) | wdata[7:0];
        if (wr && addr >= 8'd64 && addr < 8'd104) m_prio[addr-64] = int'(wdata[3:0]);
        m_req = !take && (bp > old_level);
        m_vec = bv;
        m_wp  = bp;
        @(posedge clk);
        #1;
        chk(req == m_req, "R9 request vs model", int'(req), int'(m_req));
        if (m_req) chk(int'(vec) == m_vec, "R9 vector vs model", int'(vec), m_vec);
    endtask

    task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
        wr = 1'b1; addr = a; wdata = d;
        tick();
        wr = 1'b0; wdata = '0;
    endtask

    task automatic rd_chk(input logic [7:0] a, input int exp, input string tag);
        wr = 1'b0; addr = a;
        #1;
        chk(int'(rdata) == exp, tag, int'(rdata), exp);
        tick();
    endtask

    task automatic ack_once();
        ack = 1'b1;
        tick();
        ack = 1'b0;
    endtask

    initial begin
        #(8 * 200000);
        nerr++;
        nchk++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        for (int i = 0; i < 40; i++) m_prio[i] = 0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset state
        chk(req == 1'b0, "R1 request after reset", int'(req), 0);
        rd_chk(8'h00, 0, "R1 running level after reset");
        rd_chk(8'h54, 0, "R1 source level after reset");
        rd_chk(8'h02, 0, "R1 software flags after reset");

        // R4 level register, R2 vector of a line, R9 latency
        wr_reg(8'h4B, 32'h5);
        rd_chk(8'h4B, 5, "R4 level readback");
        hw[3] = 1'b1;
        chk(req == 1'b0, "R9 no request before edge", int'(req), 0);
        tick();
        chk(req == 1'b1, "R9 request one clock after line", int'(req), 1);
        chk(int'(vec) == 11, "R2 line 3 maps to vector 11", int'(vec), 11);

        // R7 level zero never requests
        hw[4] = 1'b1;
        hw[3] = 1'b0;
        tick(); tick();
        chk(req == 1'b0, "R7 level-0 line stays silent", int'(req), 0);
        hw = '0;

        // R6 tie-break among lines, then software flag against a line
        wr_reg(8'h4D, 32'h7);
        wr_reg(8'h4E, 32'h7);
        hw[5] = 1'b1; hw[6] = 1'b1;
        tick();
        chk(int'(vec) == 13, "R6 lowest vector wins tie", int'(vec), 13);
        wr_reg(8'h42, 32'h7);
        wr_reg(8'h02, 32'h0000_0004);
        tick();
        chk(int'(vec) == 2, "R6 software flag 2 beats line on tie (R2 vector 2)", int'(vec), 2);

        // R3 set/clear semantics
        wr_reg(8'h02, 32'h0000_0404);
        rd_chk(8'h02, 4, "R3 set and clear together leaves set");
        wr_reg(8'h02, 32'h0000_0400);
        rd_chk(8'h02, 0, "R3 clear bit");
        wr_reg(8'h02, 32'h0000_0081);
        rd_chk(8'h02, 129, "R3 set two flags");
        wr_reg(8'h02, 32'h0000_8100);
        rd_chk(8'h02, 0, "R3 clear two flags");

        // R5 highest level wins
        wr_reg(8'h52, 32'h9);
        hw[10] = 1'b1;
        tick(); tick();
        chk(int'(vec) == 18, "R5 higher level wins", int'(vec), 18);

        // R8 strict compare against running level
        wr_reg(8'h00, 32'h9);
        tick();
        chk(req == 1'b0, "R8 equal level is masked", int'(req), 0);
        rd_chk(8'h00, 9, "R8 running level readback");
        wr_reg(8'h52, 32'hA);
        tick();
        chk(req == 1'b1 && int'(vec) == 18, "R8 level above mask requests", int'(vec), 18);
        wr_reg(8'h00, 32'h0);
        tick();

        // R10 acknowledge, nesting; R11 end of service
        ack_once();
        chk(req == 1'b0, "R10 request dropped after ack", int'(req), 0);
        rd_chk(8'h00, 10, "R10 level loaded on ack");
        wr_reg(8'h54, 32'hC);
        hw[12] = 1'b1;
        tick(); tick();
        chk(req == 1'b1 && int'(vec) == 20, "R10 nested preemption", int'(vec), 20);
        ack_once();
        rd_chk(8'h00, 12, "R10 nested level");
        hw[12] = 1'b0;
        wr_reg(8'h01, 32'h0);
        rd_chk(8'h00, 10, "R11 first pop");
        wr_reg(8'h01, 32'h0);
        rd_chk(8'h00, 0, "R11 second pop");
        wr_reg(8'h00, 32'h3);
        wr_reg(8'h01, 32'h0);
        rd_chk(8'h00, 0, "R11 pop of empty stack gives 0");

        // R10 ack with no request is ignored
        wr_reg(8'h00, 32'hF);
        tick(); tick();
        ack_once();
        rd_chk(8'h00, 15, "R10 ack ignored when idle");
        wr_reg(8'h00, 32'h0);
        tick(); tick();

        // R12 ack beats level write and end-of-service write
        hw[12] = 1'b1;
        tick(); tick();
        chk(int'(vec) == 20, "R12 setup vector 20", int'(vec), 20);
        hw[12] = 1'b0;
        tick(); tick();
        chk(int'(vec) == 18, "R12 setup vector 18", int'(vec), 18);
        ack = 1'b1;
        wr_reg(8'h00, 32'h2);
        ack = 1'b0;
        rd_chk(8'h00, 10, "R12 ack wins over level write");
        hw[12] = 1'b1;
        tick(); tick();
        ack = 1'b1;
        wr_reg(8'h01, 32'h0);
        ack = 1'b0;
        rd_chk(8'h00, 12, "R12 ack wins over end-of-service");
        wr_reg(8'h01, 32'h0);
        rd_chk(8'h00, 10, "R12 stack kept both entries");
        wr_reg(8'h01, 32'h0);
        rd_chk(8'h00, 0, "R11 stack emptied");

        // mixed random traffic checked against the model every cycle
        for (int n = 0; n < 600; n++) begin
            int r;
            hw = $urandom & $urandom & $urandom;
            wr = ($urandom % 3) == 0;
            r = $urandom % 8;
            if (r < 4) begin
                addr = 8'(64 + $urandom % 40); wdata = 32'($urandom % 16);
            end else if (r == 4) begin
                addr = 8'h02; wdata = $urandom & 32'hFFFF;
            end else if (r == 5) begin
                addr = 8'h00; wdata = 32'($urandom % 16);
            end else begin
                addr = 8'h01; wdata = '0;
            end
            ack = ($urandom % 3) == 0;
            tick();
        end
        wr = 1'b0; ack = 1'b0; hw = '0;

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule